// File: doc/BRIEF.md
# Reset, Soft-Init and Service-Request Sequencer

This block steps a processor core from hardware reset to its first instruction fetch. The level of the soft-init request is sampled on the last clock of hardware reset. If that level is high, the block runs an external self-test engine and keeps the word it returns. It then fires a one-cycle register-initialisation strobe and raises a first-fetch request, which stays up until the fetch is acknowledged. Bus back-off and hold requests are watched during this sequence, but their only effect is to hold the fetch request down.

Once running, the block collects rising edges on four service-request lines in sticky pending latches. It hands out one grant at a time in a fixed priority order. While soft-init is held high, no grant is given, but edges are still collected. A granted soft-init sends the core back through register initialisation, and that grant is held back for as long as the stop-grant flag is set.

Top module: `reset_init_seq`

## Requirements
- R1: If `softInitReq` is high on the last clock edge at which `hwReset` is high, `bistStart` is high for exactly one cycle immediately after reset is released. If it is low, `bistStart` stays low and `regInit` is asserted in the first cycle after release.
- R2: `bistResultReg` reads zero after reset and holds the `bistResult` value presented together with `bistDone` during self-test. Zero means pass and any other value means fail.
- R3: The cycle after `bistDone` is accepted, `regInit` is asserted whatever the result value.
- R4: `regInit` lasts one cycle and is followed by `fetchReq`, which stays high until a cycle with `fetchAck` high.
- R5: While any of `busBackoff`, `busHoldReq` or `addrHoldReq` is high (seen after a two-flop synchroniser), `fetchReq` is low. These inputs change nothing else in the sequence.
- R6: `svcGrant` is zero from reset until the first fetch has been acknowledged, and it is zero in every cycle of a re-initialisation.
- R7: Rising edges on the four request lines, found after a two-flop synchroniser, are held in pending latches. They are never dropped, including while `softInitReq` is high. While `softInitReq` is high, `svcGrant` is zero.
- R8: `svcGrant` is one-hot or zero, with bit 0 = cache flush, bit 1 = management interrupt, bit 2 = soft init and bit 3 = critical interrupt. The lowest set pending bit wins. A grant stays up until `svcAck`, which clears that latch.
- R9: Acknowledging the soft-init grant (bit 2) asserts `regInit` on the next cycle with no self-test, then repeats the fetch handshake. Other pending requests survive this.
- R10: While `stopGrantActive` is high, the soft-init grant is withheld. It is given once the flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwReset | input | 1 | Synchronous active-high hardware reset |
| cacheFlushReq | input | 1 | Cache flush request (edge) |
| mgmtIrq | input | 1 | Management-mode interrupt (edge) |
| softInitReq | input | 1 | Soft initialisation request (edge and level) |
| critIrq | input | 1 | Critical non-maskable interrupt (edge) |
| busBackoff | input | 1 | Bus back-off request |
| busHoldReq | input | 1 | Bus hold request |
| addrHoldReq | input | 1 | Address hold request |
| stopGrantActive | input | 1 | Core is in stop-grant state |
| bistDone | input | 1 | Self-test engine finished |
| bistResult | input | 32 | Self-test result word |
| fetchAck | input | 1 | First code fetch accepted |
| svcAck | input | 1 | Current service grant accepted |
| bistStart | output | 1 | One-cycle self-test launch strobe |
| regInit | output | 1 | One-cycle register initialisation strobe |
| fetchReq | output | 1 | First code fetch request |
| svcGrant | output | 4 | One-hot service grant |
| bistResultReg | output | 32 | Stored self-test result |

## Verification
The hardest state to reach is one where several latches are pending behind a held soft-init, and the soft-init grant itself then triggers a re-initialisation while a lower-priority request is still waiting. The bench holds `softInitReq` high and pulses the other lines, each for longer than the synchroniser, while grants stay blocked. It then releases soft-init and acknowledges the grants one by one. After the re-init fetch handshake, it checks that the critical interrupt is still pending. A second scenario parks the core in stop-grant, pulses soft-init, and checks that the soft-init grant is held back until the flag drops.

// File: rtl/ris_pkg.sv
package ris_pkg;
  localparam int NUM_REQ  = 4;
  localparam int NUM_HOLD = 3;
  localparam int IDX_FLUSH = 0;
  localparam int IDX_MGMT  = 1;
  localparam int IDX_INIT  = 2;
  localparam int IDX_CRIT  = 3;

  typedef enum logic [2:0] {
    sHold      = 3'd0,
    sSelfTest  = 3'd1,
    sRegInit   = 3'd2,
    sFetchWait = 3'd3,
    sRun       = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic svcEnable;
    logic captureResult;
  } ctl_strobes_t;
endpackage

// File: rtl/ris_sync.sv
module ris_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             hwReset,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (hwReset) chain <= '0;
    else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ris_ctrl.sv
module ris_ctrl
  import ris_pkg::*;
(
  input  logic         clk,
  input  logic         hwReset,
  input  logic         softInitRaw,
  input  logic         bistDone,
  input  logic         fetchAck,
  input  logic         busHeld,
  input  logic         initGrantAck,
  output logic         bistStart,
  output logic         regInit,
  output logic         fetchReq,
  output ctl_strobes_t strb
);
  seq_state_t state, nextState;
  logic bistSel;
  logic bistBusy;

  always_ff @(posedge clk) begin
    if (hwReset) begin
      state    <= sHold;
      bistSel  <= softInitRaw;
      bistBusy <= 1'b0;
    end else begin
      state    <= nextState;
      bistBusy <= (state == sSelfTest);
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      sHold:      nextState = bistSel ? sSelfTest : sRegInit;
      sSelfTest:  if (bistDone) nextState = sRegInit;
      sRegInit:   nextState = sFetchWait;
      sFetchWait: if (fetchReq && fetchAck) nextState = sRun;
      sRun:       if (initGrantAck) nextState = sRegInit;
      default:    nextState = sHold;
    endcase
  end

  assign bistStart          = (state == sSelfTest) && !bistBusy;
  assign regInit            = (state == sRegInit);
  assign fetchReq           = (state == sFetchWait) && !busHeld;
  assign strb.svcEnable     = (state == sRun);
  assign strb.captureResult = (state == sSelfTest) && bistDone;

  // R1
  bist_pulse_chk: assert property (@(posedge clk) disable iff (hwReset)
    bistStart |=> !bistStart);
  // R3
  bist_to_init_chk: assert property (@(posedge clk) disable iff (hwReset)
    (state == sSelfTest && bistDone) |=> regInit);
  // R4
  init_to_fetch_chk: assert property (@(posedge clk) disable iff (hwReset)
    regInit |=> (state == sFetchWait));
  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (hwReset)
    (state == sFetchWait && !fetchAck) |=> (state == sFetchWait));
endmodule

// File: rtl/ris_dp.sv
module ris_dp
  import ris_pkg::*;
#(
  parameter int RESULT_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                hwReset,
  input  logic [NUM_REQ-1:0]  reqRaw,
  input  logic [NUM_HOLD-1:0] holdRaw,
  input  logic                stopGrant,
  input  logic                svcAck,
  input  logic [RESULT_W-1:0] bistResult,
  input  ctl_strobes_t        strb,
  output logic [NUM_REQ-1:0]  grant,
  output logic                busHeld,
  output logic                initGrantAck,
  output logic [RESULT_W-1:0] resultWord
);
  localparam int SYNC_W = NUM_REQ + NUM_HOLD;
  localparam logic [NUM_REQ-1:0] ONE_HOT0 = NUM_REQ'(1);

  logic [SYNC_W-1:0]  syncOut;
  logic [NUM_REQ-1:0] reqSync, reqPrev, reqRise, pending, eligible, mask;
  logic [NUM_HOLD-1:0] holdSync;
  logic initActive;

  ris_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .hwReset(hwReset), .din({holdRaw, reqRaw}), .dout(syncOut)
  );

  assign reqSync    = syncOut[NUM_REQ-1:0];
  assign holdSync   = syncOut[SYNC_W-1:NUM_REQ];
  assign reqRise    = reqSync & ~reqPrev;
  assign initActive = reqSync[IDX_INIT];
  assign busHeld    = |holdSync;

  always_ff @(posedge clk) begin
    if (hwReset) begin
      reqPrev    <= '0;
      pending    <= '0;
      resultWord <= '0;
    end else begin
      reqPrev <= reqSync;
      pending <= (pending & ~(grant & {NUM_REQ{svcAck}})) | reqRise;
      if (strb.captureResult) resultWord <= bistResult;
    end
  end

  always_comb begin
    mask = {NUM_REQ{strb.svcEnable && !initActive}};
    mask[IDX_INIT] = mask[IDX_INIT] && !stopGrant;
  end

  assign eligible     = pending & mask;
  assign grant        = eligible & (~eligible + ONE_HOT0);
  assign initGrantAck = grant[IDX_INIT] && svcAck;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (hwReset)
    $onehot0(grant));
  // R7
  no_lost_req_chk: assert property (@(posedge clk) disable iff (hwReset)
    ((~pending & $past(pending) & ~$past(grant & {NUM_REQ{svcAck}})) == '0));
  // R10
  stop_grant_chk: assert property (@(posedge clk) disable iff (hwReset)
    grant[IDX_INIT] |-> !stopGrant);
  // R6
  grant_in_run_chk: assert property (@(posedge clk) disable iff (hwReset)
    (grant != '0) |-> strb.svcEnable);
endmodule

// File: rtl/reset_init_seq.sv
module reset_init_seq
  import ris_pkg::*;
#(
  parameter int RESULT_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                hwReset,
  input  logic                cacheFlushReq,
  input  logic                mgmtIrq,
  input  logic                softInitReq,
  input  logic                critIrq,
  input  logic                busBackoff,
  input  logic                busHoldReq,
  input  logic                addrHoldReq,
  input  logic                stopGrantActive,
  input  logic                bistDone,
  input  logic [RESULT_W-1:0] bistResult,
  input  logic                fetchAck,
  input  logic                svcAck,
  output logic                bistStart,
  output logic                regInit,
  output logic                fetchReq,
  output logic [NUM_REQ-1:0]  svcGrant,
  output logic [RESULT_W-1:0] bistResultReg
);
  ctl_strobes_t strb;
  logic busHeld, initGrantAck;
  logic [NUM_REQ-1:0] reqRaw;

  always_comb begin
    reqRaw = '0;
    reqRaw[IDX_FLUSH] = cacheFlushReq;
    reqRaw[IDX_MGMT]  = mgmtIrq;
    reqRaw[IDX_INIT]  = softInitReq;
    reqRaw[IDX_CRIT]  = critIrq;
  end

  ris_ctrl u_ctrl (
    .clk(clk), .hwReset(hwReset), .softInitRaw(softInitReq),
    .bistDone(bistDone), .fetchAck(fetchAck), .busHeld(busHeld),
    .initGrantAck(initGrantAck), .bistStart(bistStart), .regInit(regInit),
    .fetchReq(fetchReq), .strb(strb)
  );

  ris_dp #(.RESULT_W(RESULT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .hwReset(hwReset), .reqRaw(reqRaw),
    .holdRaw({addrHoldReq, busHoldReq, busBackoff}),
    .stopGrant(stopGrantActive), .svcAck(svcAck), .bistResult(bistResult),
    .strb(strb), .grant(svcGrant), .busHeld(busHeld),
    .initGrantAck(initGrantAck), .resultWord(bistResultReg)
  );
endmodule

// File: tb/sim_reset_init_seq.sv
`timescale 1ns/1ps
module sim_reset_init_seq;
  logic clk = 1'b0;
  logic hwReset = 1'b1;
  logic cacheFlushReq = 0, mgmtIrq = 0, softInitReq = 0, critIrq = 0;
  logic busBackoff = 0, busHoldReq = 0, addrHoldReq = 0, stopGrantActive = 0;
  logic bistDone = 0, fetchAck = 0, svcAck = 0;
  logic [31:0] bistResult = '0;
  logic bistStart, regInit, fetchReq;
  logic [3:0] svcGrant;
  logic [31:0] bistResultReg;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  reset_init_seq u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic withBist, input logic holdBus);
    @(negedge clk);
    hwReset = 1; softInitReq = withBist; addrHoldReq = holdBus;
    cyc(3);
    hwReset = 0; softInitReq = 0;
  endtask

  task automatic ackFetch();
    fetchAck = 1; @(negedge clk); fetchAck = 0;
  endtask

  task automatic ackSvc();
    svcAck = 1; @(negedge clk); svcAck = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; cyc(4); sig = 0; cyc(2);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R6 grant in reset", svcGrant, 0);
    chk("R4 fetchReq in reset", fetchReq, 0);
    chk("R1 bistStart in reset", bistStart, 0);
    chk("R2 result after reset", bistResultReg, 0);
  endtask

  task automatic tBootBist();
    doReset(1'b1, 1'b0);
    @(negedge clk);
    chk("R1 bistStart pulse", bistStart, 1);
    @(negedge clk);
    chk("R1 bistStart one cycle", bistStart, 0);
    cyc(2);
    bistDone = 1; bistResult = 32'hDEAD0001;
    @(negedge clk);
    bistDone = 0; bistResult = 0;
    chk("R3 regInit after failed test", regInit, 1);
    chk("R2 result captured", bistResultReg, 32'hDEAD0001);
    @(negedge clk);
    chk("R4 regInit single cycle", regInit, 0);
    chk("R4 fetchReq up", fetchReq, 1);
    cyc(3);
    chk("R4 fetchReq held", fetchReq, 1);
    ackFetch();
    chk("R4 fetchReq drops after ack", fetchReq, 0);
  endtask

  task automatic tBootPlain();
    doReset(1'b0, 1'b0);
    @(negedge clk);
    chk("R1 no bist regInit", regInit, 1);
    chk("R1 no bistStart", bistStart, 0);
    chk("R2 result cleared", bistResultReg, 0);
    @(negedge clk);
    ackFetch();
  endtask

  task automatic tBusHold();
    doReset(1'b0, 1'b1);
    cyc(5);
    chk("R5 fetch stalled", fetchReq, 0);
    chk("R5 no extra regInit", regInit, 0);
    addrHoldReq = 0;
    cyc(3);
    chk("R5 fetch after release", fetchReq, 1);
    busBackoff = 1; cyc(3);
    chk("R5 backoff stalls fetch", fetchReq, 0);
    busBackoff = 0; cyc(3);
    ackFetch();
  endtask

  task automatic tFetchFirst();
    doReset(1'b0, 1'b0);
    cyc(2);
    pulse(critIrq);
    cyc(3);
    chk("R6 no grant before fetch", svcGrant, 0);
    chk("R6 fetch still pending", fetchReq, 1);
    ackFetch();
    chk("R6 grant after fetch", svcGrant, 4'b1000);
    ackSvc();
    chk("R8 grant cleared by ack", svcGrant, 0);
  endtask

  task automatic tLatchDuringInit();
    softInitReq = 1; cyc(4);
    pulse(cacheFlushReq);
    pulse(critIrq);
    pulse(mgmtIrq);
    cyc(3);
    chk("R7 no grant while init high", svcGrant, 0);
    softInitReq = 0; cyc(5);
    chk("R8 flush first", svcGrant, 4'b0001);
    ackSvc();
    chk("R8 mgmt second", svcGrant, 4'b0010);
    ackSvc();
    chk("R8 init third", svcGrant, 4'b0100);
    ackSvc();
    chk("R9 reinit strobe", regInit, 1);
    chk("R6 no grant during reinit", svcGrant, 0);
    chk("R9 no bist on reinit", bistStart, 0);
    @(negedge clk);
    chk("R9 fetch after reinit", fetchReq, 1);
    ackFetch();
    chk("R7 crit survived reinit", svcGrant, 4'b1000);
    ackSvc();
    chk("R8 all clear", svcGrant, 0);
  endtask

  task automatic tStopGrant();
    stopGrantActive = 1; cyc(2);
    pulse(softInitReq);
    cyc(8);
    chk("R10 init withheld", svcGrant, 0);
    chk("R10 no reinit", regInit, 0);
    stopGrantActive = 0;
    @(negedge clk);
    chk("R10 init granted after exit", svcGrant, 4'b0100);
    ackSvc();
    chk("R9 reinit after stop grant", regInit, 1);
    @(negedge clk);
    ackFetch();
  endtask

  initial begin
    #(20ns * 100000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(2);
    tReset();
    tBootBist();
    tBootPlain();
    tBusHold();
    tFetchFirst();
    tLatchDuringInit();
    tStopGrant();
    cyc(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule